// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This block is a memory-mapped real-time clock that keeps a 32-bit count of seconds. An external one-cycle pulse arrives once per second and advances the count. Software can set the count at any time through a preset register, and can read the count back at any time. A compare register sets an alarm. When a tick brings the count to the compare value, a sticky status bit is set. That bit can be masked onto a level interrupt output and cleared by software.

The register bus is deliberately simple: a byte address into a 4 KB window, a write strobe, write data and read data. Read data is registered. It shows the register addressed in the previous cycle. The run control reads as always on and cannot be turned off. The top 32 bytes of the window return a fixed identification sequence, one byte per word. The address decode uses the word index (address bits 11:2), and address bits 1:0 are ignored.

Top module: `rtc_sec_top`

## Requirements
- R1: After reset the count, compare, preset, mask and raw status are all zero, and `irq_o` is low.
- R2: A write to offset 0x08 (preset) sets the count to the written value. A read of 0x08 returns the last value written there, not the running count.
- R3: Each cycle with `tick_i` high and no preset write adds one to the count. A read of offset 0x00 returns the count.
- R4: A preset write in the same cycle as a tick wins, and the count takes the written value with no increment.
- R5: A read of offset 0x04 (compare) returns its last written value. Raw status (offset 0x14, bit 0) is set on a tick whose incremented count equals the compare value.
- R6: A write of any value to offset 0x1C clears raw status. A read of 0x1C returns 0.
- R7: If a clear write and a setting tick fall in the same cycle, raw status ends up set.
- R8: A write to offset 0x10 (mask) stores only bit 0. A read returns that bit with all upper bits zero.
- R9: Offset 0x18 reads raw AND mask, and `irq_o` is high exactly when both are set.
- R10: Offset 0x0C reads 1 and ignores writes.
- R11: Offsets 0x020 to 0xFDC read 0, and writes to them change nothing.
- R12: Offsets 0xFE0 to 0xFFC return, in their low byte, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending address order. The upper bits are zero, and writes to this range are ignored.
- R13: The count wraps from 0xFFFFFFFF to 0 on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Level interrupt, active high: raw status AND mask |

## Verification
The counter is driven with plain tick runs, with a preset followed by ticks, and with a tick that wraps the count. Together these separate correct increments from a stalled count or a dropped carry. The alarm is tried in three ways. A tick one short of the compare value must leave status clear, and the tick that reaches it must set status. A clear written in the same cycle as that tick shows which side has priority. Mask writes that carry only the upper bits, followed by writes with bit 0 set, show whether stray bits are kept. Writes to the control, reserved and identification ranges, each followed by a readback, show that those writes leave no trace.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int WIDX_W = ADDR_W - 2;

  // word indices within the window
  localparam logic [WIDX_W-1:0] W_COUNT  = 10'h000;
  localparam logic [WIDX_W-1:0] W_CMP    = 10'h001;
  localparam logic [WIDX_W-1:0] W_PRESET = 10'h002;
  localparam logic [WIDX_W-1:0] W_RUN    = 10'h003;
  localparam logic [WIDX_W-1:0] W_MASK   = 10'h004;
  localparam logic [WIDX_W-1:0] W_RAW    = 10'h005;
  localparam logic [WIDX_W-1:0] W_MSTAT  = 10'h006;
  localparam logic [WIDX_W-1:0] W_CLR    = 10'h007;
  localparam logic [WIDX_W-1:0] W_IDBASE = 10'h3F8;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h31;
      3'd1: b = 8'h10;
      3'd2: b = 8'h14;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             preset_we,
  input  logic [CNT_W-1:0] preset_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count_q,
  output logic             hit_o
);
  logic [CNT_W-1:0] inc;
  assign inc   = count_q + 1'b1;
  assign hit_o = tick_i && !preset_we && (inc == cmp_val);

  always_ff @(posedge clk) begin
    if (rst)            count_q <= '0;
    else if (preset_we) count_q <= preset_val;
    else if (tick_i)    count_q <= inc;
  end
endmodule

// File: rtl/rtc_sec_irq.sv
module rtc_sec_irq (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  input  logic clr_we,
  input  logic mask_we,
  input  logic mask_bit,
  output logic raw_q,
  output logic mask_q,
  output logic irq_q
);
  logic raw_d, mask_d;

  always_comb begin
    raw_d = raw_q;
    if (clr_we) raw_d = 1'b0;
    if (hit_i)  raw_d = 1'b1;
    mask_d = mask_we ? mask_bit : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      irq_q  <= raw_d & mask_d;
    end
  end
endmodule

// File: rtl/rtc_sec_rdmux.sv
module rtc_sec_rdmux
  import rtc_sec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDX_W-1:0] widx,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] cmp,
  input  logic [DATA_W-1:0] preset,
  input  logic              mask,
  input  logic              raw,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] rd;

  always_comb begin
    rd = '0;
    case (widx)
      W_COUNT:  rd = count;
      W_CMP:    rd = cmp;
      W_PRESET: rd = preset;
      W_RUN:    rd = {{(DATA_W-1){1'b0}}, 1'b1};
      W_MASK:   rd = {{(DATA_W-1){1'b0}}, mask};
      W_RAW:    rd = {{(DATA_W-1){1'b0}}, raw};
      W_MSTAT:  rd = {{(DATA_W-1){1'b0}}, raw & mask};
      default: begin
        if (widx >= W_IDBASE) rd = {{(DATA_W-8){1'b0}}, id_byte(widx[2:0])};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd;
  end
endmodule

// File: rtl/rtc_sec_top.sv
module rtc_sec_top
  import rtc_sec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [WIDX_W-1:0] widx;
  logic              wr_preset, wr_cmp, wr_mask, wr_clr;
  logic [DATA_W-1:0] count_w, cmp_q, preset_q;
  logic              hit_w, raw_w, mask_w;

  assign widx      = bus_addr[ADDR_W-1:2];
  assign wr_preset = bus_we && (widx == W_PRESET);
  assign wr_cmp    = bus_we && (widx == W_CMP);
  assign wr_mask   = bus_we && (widx == W_MASK);
  assign wr_clr    = bus_we && (widx == W_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q    <= '0;
      preset_q <= '0;
    end else begin
      if (wr_cmp)    cmp_q    <= bus_wdata;
      if (wr_preset) preset_q <= bus_wdata;
    end
  end

  rtc_sec_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .preset_we(wr_preset), .preset_val(bus_wdata), .cmp_val(cmp_q),
    .count_q(count_w), .hit_o(hit_w)
  );

  rtc_sec_irq u_irq (
    .clk(clk), .rst(rst), .hit_i(hit_w), .clr_we(wr_clr),
    .mask_we(wr_mask), .mask_bit(bus_wdata[0]),
    .raw_q(raw_w), .mask_q(mask_w), .irq_q(irq_o)
  );

  rtc_sec_rdmux u_rd (
    .clk(clk), .rst(rst), .widx(widx),
    .count(count_w), .cmp(cmp_q), .preset(preset_q),
    .mask(mask_w), .raw(raw_w), .rdata_q(bus_rdata)
  );
endmodule

// File: rtl/rtc_sec_chk.sv
module rtc_sec_chk (
  input logic        clk,
  input logic        rst,
  input logic        tick_i,
  input logic        bus_we,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] count,
  input logic        raw,
  input logic        mask,
  input logic        irq_o
);
  logic wr_preset, wr_clr;
  assign wr_preset = bus_we && (bus_addr[11:2] == 10'h002);
  assign wr_clr    = bus_we && (bus_addr[11:2] == 10'h007);

  // R1
  reset_zero_chk: assert property (@(posedge clk) $past(rst) |-> (count == 32'd0 && !raw && !mask && !irq_o));
  // R3
  tick_inc_chk: assert property (@(posedge clk) disable iff (rst) (tick_i && !wr_preset) |=> count == $past(count) + 32'd1);
  // R4
  preset_wins_chk: assert property (@(posedge clk) disable iff (rst) wr_preset |=> count == $past(bus_wdata));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (rst) (wr_clr && !tick_i) |=> !raw);
  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (rst) irq_o == (raw & mask));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst) (!tick_i && !wr_preset) |=> $stable(count));
endmodule

bind rtc_sec_top rtc_sec_chk u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .count(count_w), .raw(raw_w), .mask(mask_w), .irq_o(irq_o)
);

// File: tb/tb_rtc_sec_top.sv
module tb_rtc_sec_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_sec_top dut (.*);

  // op: 0 write, 1 read and compare, 2 one tick
  localparam int NV = 33;
  localparam logic [45:0] VEC [NV] = '{
    {2'd1, 12'h000, 32'h0},        // R1 count
    {2'd1, 12'h004, 32'h0},        // R1 compare
    {2'd1, 12'h008, 32'h0},        // R1 preset
    {2'd1, 12'h010, 32'h0},        // R1 mask
    {2'd1, 12'h014, 32'h0},        // R1 raw
    {2'd0, 12'h008, 32'h100},      // R2 preset
    {2'd1, 12'h000, 32'h100},      // R2 count takes preset
    {2'd2, 12'h000, 32'h0},
    {2'd2, 12'h000, 32'h0},
    {2'd2, 12'h000, 32'h0},
    {2'd1, 12'h000, 32'h103},      // R3 three ticks
    {2'd1, 12'h008, 32'h100},      // R2 preset readback not count
    {2'd0, 12'h004, 32'h105},
    {2'd1, 12'h004, 32'h105},      // R5 compare readback
    {2'd2, 12'h000, 32'h0},
    {2'd1, 12'h014, 32'h0},        // R5 one short: clear
    {2'd2, 12'h000, 32'h0},
    {2'd1, 12'h014, 32'h1},        // R5 reached: set
    {2'd1, 12'h018, 32'h0},        // R9 masked off
    {2'd0, 12'h010, 32'hFFFFFFFE},
    {2'd1, 12'h010, 32'h0},        // R8 upper bits dropped
    {2'd0, 12'h010, 32'h00000003},
    {2'd1, 12'h010, 32'h1},        // R8 bit 0 only
    {2'd1, 12'h018, 32'h1},        // R9 raw and mask
    {2'd0, 12'h01C, 32'hABCD},
    {2'd1, 12'h014, 32'h0},        // R6 clear
    {2'd1, 12'h01C, 32'h0},        // R6 reads 0
    {2'd0, 12'h00C, 32'h0},
    {2'd1, 12'h00C, 32'h1},        // R10 run stays on
    {2'd0, 12'h040, 32'hDEAD},
    {2'd1, 12'h040, 32'h0},        // R11 reserved
    {2'd0, 12'hFE0, 32'h77},
    {2'd1, 12'hFE0, 32'h31}        // R12 id untouched
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic tick1();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  logic [31:0] v;
  logic [7:0] ids [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][45:44])
        2'd0: wr(VEC[i][43:32], VEC[i][31:0]);
        2'd1: begin
          rd(VEC[i][43:32], v);
          $display("vec %0d", i);
          chk("table", v, VEC[i][31:0]);
        end
        default: tick1();
      endcase
    end
    // R12 full id sequence
    for (int k = 0; k < 8; k++) begin
      rd(12'hFE0 + 12'(k*4), v);
      chk("R12 id", v, {24'b0, ids[k]});
    end
    // R9 irq level with mask on, raw set again
    wr(12'h008, 32'h104);
    tick1();
    chk("R9 irq high", {31'b0, irq_o}, 32'h1);
    wr(12'h01C, 32'h0);
    chk("R9 irq low after clear", {31'b0, irq_o}, 32'h0);
    // R7 set wins over clear
    wr(12'h008, 32'h104);
    @(negedge clk); tick_i = 1'b1; bus_addr = 12'h01C; bus_we = 1'b1; bus_wdata = 32'h5;
    @(negedge clk); tick_i = 1'b0; bus_we = 1'b0;
    rd(12'h014, v);
    chk("R7 set wins", v, 32'h1);
    wr(12'h01C, 32'h0);
    // R4 preset with tick
    @(negedge clk); tick_i = 1'b1; bus_addr = 12'h008; bus_we = 1'b1; bus_wdata = 32'h2000;
    @(negedge clk); tick_i = 1'b0; bus_we = 1'b0;
    rd(12'h000, v);
    chk("R4 preset wins", v, 32'h2000);
    rd(12'h014, v);
    chk("R4 no alarm", v, 32'h0);
    // R13 wrap
    wr(12'h008, 32'hFFFFFFFF);
    tick1();
    rd(12'h000, v);
    chk("R13 wrap", v, 32'h0);
    // R1 reset mid run
    wr(12'h008, 32'h55);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(12'h000, v);
    chk("R1 count after reset", v, 32'h0);
    rd(12'h010, v);
    chk("R1 mask after reset", v, 32'h0);
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule